// File: doc/BRIEF.md
# Card Status Register with Per-Bit Clear Rules

This block holds the 32-bit card status word that a memory card reports in its short command responses. The card's command logic sends it one-cycle event pulses, one for each error or status condition. It also sends a strobe when a valid command has been received, a strobe when the status word is being read out, and the current state code of the card state machine. The register applies the clear rule that belongs to each bit. Most error flags stay set until the word is read. The command-CRC and illegal-command flags describe the previous command, so they survive one further valid command and clear at the next. The lock, ECC-disable and ready-for-data flags are live copies of the card's condition.

Besides the native word, the block produces a 16-bit status view for SPI-mode responses. Its low byte is a one-byte response code and its high byte carries the second status byte. Several native flags are folded into single bits there. An idle flag is derived from the state code. A parameter-error flag is latched from its own event input. The command decoder and the response serializer sit outside this block.

Top module: `card_status_reg`

## Requirements
- R1: A pulse on `evtPulse[b]` sets status bit b at the next clock edge, for b in {31..26, 24..15, 13, 5}. Once set, the bit stays set until its own clear rule removes it.
- R2: Bits 31..26, 24, 21..16, 15, 13 and 5 clear on the clock edge that ends a cycle with `statusRd` high. During that cycle `statusWord` still shows them.
- R3: Bits 23 and 22 clear on the second clock edge with `validCmd` high after the bit was set. The first such edge leaves them set. `statusRd` has no effect on them.
- R4: When an event pulse and a clear for the same bit fall in the same cycle, the bit is set after the edge. For bits 23/22 this restarts the count of valid commands.
- R5: Bit 25 equals `cardLocked`, bit 14 equals `eccDisabled` and bit 8 equals `readyForData` in the same cycle, without latching.
- R6: Bits 12:9 equal `cardState` in the same cycle.
- R7: Bits 7, 6 and 4..0 always read 0. Event pulses on those positions, and on bits 25, 14 and 12..8, have no effect.
- R8: `spiStatus[7:0]` is defined bit by bit as follows. Bit 0 is 1 exactly when `cardState` is 0. Bit 1 is status bit 13. Bit 2 is status bit 22. Bit 3 is status bit 23. Bit 4 is status bit 28. Bit 5 is status bit 30. Bit 6 is the latched parameter error. Bit 7 is 0.
- R9: `spiStatus[15:8]` is defined bit by bit as follows. Bit 8 is status bit 25. Bit 9 is status bit 15 OR status bit 24. Bit 10 is status bit 19. Bit 11 is status bit 20. Bit 12 is status bit 21. Bit 13 is status bit 26. Bit 14 is status bit 27. Bit 15 is status bit 31 OR status bit 16.
- R10: A pulse on `argErrEvt` sets the parameter error at the next edge. A read clears it, and an event in the same cycle as a read wins. It has no native status bit.
- R11: While `rstN` is low, all latched flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtPulse | input | 32 | Event pulses, one per native status bit position |
| argErrEvt | input | 1 | Argument (parameter) error event for the SPI view |
| validCmd | input | 1 | One-cycle strobe: a valid command was received |
| statusRd | input | 1 | One-cycle strobe: status word is being read out |
| cardState | input | 4 | Current card state code |
| cardLocked | input | 1 | Live card-locked condition |
| eccDisabled | input | 1 | Live ECC-disabled condition |
| readyForData | input | 1 | Live ready-for-data condition |
| statusWord | output | 32 | Native status word |
| spiStatus | output | 16 | SPI-mode status view (second byte high, first byte low) |

## Verification
The assertions assume that every input is a known value in every cycle, including the cycle in which reset is released. They do not assume that the strobes are exclusive or one cycle wide: an event, a read and a valid command may all coincide. The stimulus drives every input to a defined level from time zero. It changes inputs only on the falling clock edge. It deliberately lines up events with reads and valid commands to reach the priority cases.

// File: rtl/cstat_pkg.sv
package cstat_pkg;
  localparam int WORD_W  = 32;
  localparam int SPI_W   = 16;
  localparam int STATE_W = 4;
  localparam int STATE_LSB = 9;
  localparam int PREV_N  = 2;
  localparam int PREV_LSB = 22;
  localparam logic [WORD_W-1:0] RDCLR_MASK = 32'hFD3F_A020;
  localparam logic [WORD_W-1:0] PREV_MASK  = 32'h00C0_0000;
  localparam logic [WORD_W-1:0] LATCH_MASK = RDCLR_MASK | PREV_MASK;

  typedef struct packed {
    logic clrRead;
    logic ageCmd;
  } ctrlStrobes_t;
endpackage

// File: rtl/cstat_ctrl.sv
module cstat_ctrl
  import cstat_pkg::*;
(
  input  logic         statusRd,
  input  logic         validCmd,
  output ctrlStrobes_t strb
);
  always_comb begin
    strb.clrRead = statusRd;
    strb.ageCmd  = validCmd;
  end
endmodule

// File: rtl/cstat_datapath.sv
module cstat_datapath
  import cstat_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strb,
  input  logic [WORD_W-1:0]  evtPulse,
  input  logic               argErrEvt,
  input  logic [STATE_W-1:0] cardState,
  input  logic               cardLocked,
  input  logic               eccDisabled,
  input  logic               readyForData,
  output logic [WORD_W-1:0]  statusWord,
  output logic               paramErr
);
  logic [WORD_W-1:0] rdBits;
  logic [PREV_N-1:0] prevBits;
  logic [PREV_N-1:0] prevAged;

  // clear-on-read group: event wins over the clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdBits   <= '0;
      paramErr <= 1'b0;
    end else begin
      rdBits   <= ((rdBits & ~(strb.clrRead ? RDCLR_MASK : '0)) | evtPulse) & RDCLR_MASK;
      paramErr <= argErrEvt | (paramErr & ~strb.clrRead);
    end
  end

  // previous-command group: survives one valid command, clears on the next
  for (genvar i = 0; i < PREV_N; i++) begin : gPrev
    always_ff @(posedge clk) begin
      if (!rstN) begin
        prevBits[i] <= 1'b0;
        prevAged[i] <= 1'b0;
      end else if (evtPulse[PREV_LSB+i]) begin
        prevBits[i] <= 1'b1;
        prevAged[i] <= 1'b0;
      end else if (strb.ageCmd && prevBits[i]) begin
        prevBits[i] <= ~prevAged[i];
        prevAged[i] <= ~prevAged[i];
      end
    end
  end

  always_comb begin
    statusWord = rdBits;
    statusWord[PREV_LSB +: PREV_N]     = prevBits;
    statusWord[25]                     = cardLocked;
    statusWord[14]                     = eccDisabled;
    statusWord[8]                      = readyForData;
    statusWord[STATE_LSB +: STATE_W]   = cardState;
  end
endmodule

// File: rtl/cstat_spi_map.sv
module cstat_spi_map
  import cstat_pkg::*;
(
  input  logic [WORD_W-1:0]  statusWord,
  input  logic               paramErr,
  output logic [SPI_W-1:0]   spiStatus
);
  always_comb begin
    spiStatus[0]  = (statusWord[STATE_LSB +: STATE_W] == '0);
    spiStatus[1]  = statusWord[13];
    spiStatus[2]  = statusWord[22];
    spiStatus[3]  = statusWord[23];
    spiStatus[4]  = statusWord[28];
    spiStatus[5]  = statusWord[30];
    spiStatus[6]  = paramErr;
    spiStatus[7]  = 1'b0;
    spiStatus[8]  = statusWord[25];
    spiStatus[9]  = statusWord[15] | statusWord[24];
    spiStatus[10] = statusWord[19];
    spiStatus[11] = statusWord[20];
    spiStatus[12] = statusWord[21];
    spiStatus[13] = statusWord[26];
    spiStatus[14] = statusWord[27];
    spiStatus[15] = statusWord[31] | statusWord[16];
  end
endmodule

// File: rtl/card_status_reg.sv
module card_status_reg
  import cstat_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [WORD_W-1:0]  evtPulse,
  input  logic               argErrEvt,
  input  logic               validCmd,
  input  logic               statusRd,
  input  logic [STATE_W-1:0] cardState,
  input  logic               cardLocked,
  input  logic               eccDisabled,
  input  logic               readyForData,
  output logic [WORD_W-1:0]  statusWord,
  output logic [SPI_W-1:0]   spiStatus
);
  ctrlStrobes_t strb;
  logic         paramErr;

  cstat_ctrl uCtrl (
    .statusRd(statusRd),
    .validCmd(validCmd),
    .strb(strb)
  );

  cstat_datapath uDp (
    .clk(clk),
    .rstN(rstN),
    .strb(strb),
    .evtPulse(evtPulse),
    .argErrEvt(argErrEvt),
    .cardState(cardState),
    .cardLocked(cardLocked),
    .eccDisabled(eccDisabled),
    .readyForData(readyForData),
    .statusWord(statusWord),
    .paramErr(paramErr)
  );

  cstat_spi_map uSpi (
    .statusWord(statusWord),
    .paramErr(paramErr),
    .spiStatus(spiStatus)
  );
endmodule

// File: rtl/card_status_chk.sv
module card_status_chk
  import cstat_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic [WORD_W-1:0]  evtPulse,
  input logic               validCmd,
  input logic               statusRd,
  input logic [STATE_W-1:0] cardState,
  input logic               cardLocked,
  input logic [WORD_W-1:0]  statusWord,
  input logic [SPI_W-1:0]   spiStatus
);
  assert_event_sets_R1: assert property (@(posedge clk) disable iff (!rstN)
    ((evtPulse & LATCH_MASK) != '0) |=>
      ((statusWord & $past(evtPulse & LATCH_MASK)) == $past(evtPulse & LATCH_MASK)));

  assert_read_clears_R2: assert property (@(posedge clk) disable iff (!rstN)
    statusRd |=> ((statusWord & RDCLR_MASK & ~$past(evtPulse)) == '0));

  assert_hold_no_read_R2: assert property (@(posedge clk) disable iff (!rstN)
    !statusRd |=> ((statusWord & $past(statusWord & RDCLR_MASK)) == $past(statusWord & RDCLR_MASK)));

  assert_prev_ignores_read_R3: assert property (@(posedge clk) disable iff (!rstN)
    !validCmd |=> ((statusWord[23:22] & $past(statusWord[23:22])) == $past(statusWord[23:22])));

  assert_live_lock_R5: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[25] == cardLocked);

  assert_state_field_R6: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[12:9] == cardState);

  assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord[7:6] == 2'b00) && (statusWord[4:0] == 5'b0));

  assert_spi_low_R8: assert property (@(posedge clk) disable iff (!rstN)
    !spiStatus[7] && (spiStatus[2] == statusWord[22]) && (spiStatus[0] == (cardState == '0)));

  assert_spi_high_R9: assert property (@(posedge clk) disable iff (!rstN)
    spiStatus[15] == (statusWord[31] | statusWord[16]));
endmodule

bind card_status_reg card_status_chk uChk (
  .clk(clk),
  .rstN(rstN),
  .evtPulse(evtPulse),
  .validCmd(validCmd),
  .statusRd(statusRd),
  .cardState(cardState),
  .cardLocked(cardLocked),
  .statusWord(statusWord),
  .spiStatus(spiStatus)
);

// File: tb/sim_card_status_reg.sv
`timescale 1ns/1ps
module sim_card_status_reg;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] evtPulse = '0;
  logic        argErrEvt = 1'b0;
  logic        validCmd = 1'b0;
  logic        statusRd = 1'b0;
  logic [3:0]  cardState = '0;
  logic        cardLocked = 1'b0;
  logic        eccDisabled = 1'b0;
  logic        readyForData = 1'b0;
  logic [31:0] statusWord;
  logic [15:0] spiStatus;

  int checks = 0;
  int errors = 0;

  localparam logic [31:0] RDCLR = 32'hFD3F_A020;
  localparam logic [31:0] PREV  = 32'h00C0_0000;

  always #5 clk = ~clk;

  card_status_reg u0 (.*);

  function automatic logic [15:0] spiOf(input logic [31:0] w, input logic p);
    logic [15:0] s;
    s[0]  = (w[12:9] == 4'd0);
    s[1]  = w[13];  s[2] = w[22]; s[3] = w[23]; s[4] = w[28];
    s[5]  = w[30];  s[6] = p;     s[7] = 1'b0;
    s[8]  = w[25];  s[9] = w[15] | w[24];
    s[10] = w[19];  s[11] = w[20]; s[12] = w[21];
    s[13] = w[26];  s[14] = w[27]; s[15] = w[31] | w[16];
    return s;
  endfunction

  task automatic chk(input string req, input logic [31:0] expW, input logic expP);
    checks++;
    if (statusWord !== expW) begin
      errors++;
      $display("FAIL %s word act=%h exp=%h", req, statusWord, expW);
    end
    checks++;
    if (spiStatus !== spiOf(expW, expP)) begin
      errors++;
      $display("FAIL %s spi act=%h exp=%h", req, spiStatus, spiOf(expW, expP));
    end
  endtask

  task automatic tick(input logic [31:0] e, input logic a, input logic r, input logic v);
    evtPulse = e; argErrEvt = a; statusRd = r; validCmd = v;
    @(negedge clk);
    evtPulse = '0; argErrEvt = 1'b0; statusRd = 1'b0; validCmd = 1'b0;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] b1;
    @(negedge clk);
    doReset();
    chk("R11 reset", 32'h0, 1'b0);

    // R1/R2/R3/R7 sweep over every bit position
    for (int b = 0; b < 32; b++) begin
      doReset();
      b1 = 32'h1 << b;
      tick(b1, 1'b0, 1'b0, 1'b0);
      chk("R1/R7 event", b1 & (RDCLR | PREV), 1'b0);
      tick('0, 1'b0, 1'b1, 1'b0);
      chk("R2/R3 read", b1 & PREV, 1'b0);
      if ((b1 & PREV) != 0) begin
        tick('0, 1'b0, 1'b0, 1'b1);
        chk("R3 first valid cmd", b1, 1'b0);
        tick('0, 1'b0, 1'b0, 1'b1);
        chk("R3 second valid cmd", 32'h0, 1'b0);
      end
    end

    // R2: read-cycle value still visible
    doReset();
    tick(32'h8000_0000, 1'b0, 1'b0, 1'b0);
    statusRd = 1'b1; #1;
    chk("R2 visible during read", 32'h8000_0000, 1'b0);
    @(negedge clk); statusRd = 1'b0;
    chk("R2 cleared after read", 32'h0, 1'b0);

    // R4: event wins over read clear and valid-command clear
    doReset();
    tick(32'h8000_2020, 1'b0, 1'b0, 1'b0);
    tick(32'h8000_0000, 1'b0, 1'b1, 1'b0);
    chk("R4 event beats read", 32'h8000_0000, 1'b0);
    doReset();
    tick(32'h0040_0000, 1'b0, 1'b0, 1'b0);
    tick('0, 1'b0, 1'b0, 1'b1);
    tick(32'h0040_0000, 1'b0, 1'b0, 1'b1);
    chk("R4 event beats valid cmd", 32'h0040_0000, 1'b0);
    tick('0, 1'b0, 1'b0, 1'b1);
    chk("R4 count restarted", 32'h0040_0000, 1'b0);
    tick('0, 1'b0, 1'b0, 1'b1);
    chk("R4 cleared after restart", 32'h0, 1'b0);

    // R5/R6/R8 live inputs sweep
    doReset();
    for (int s = 0; s < 16; s++) begin
      for (int l = 0; l < 8; l++) begin
        cardState = 4'(s);
        cardLocked = l[0]; eccDisabled = l[1]; readyForData = l[2];
        #1;
        chk("R5/R6/R8 live", (32'(s) << 9) | (32'(l[0]) << 25) | (32'(l[1]) << 14) | (32'(l[2]) << 8), 1'b0);
        @(negedge clk);
      end
    end
    cardState = '0; cardLocked = 1'b0; eccDisabled = 1'b0; readyForData = 1'b0;
    @(negedge clk);
    chk("R5 not latched", 32'h0, 1'b0);

    // R10 parameter error
    doReset();
    tick('0, 1'b1, 1'b0, 1'b0);
    chk("R10 set", 32'h0, 1'b1);
    tick('0, 1'b1, 1'b1, 1'b0);
    chk("R10 event beats read", 32'h0, 1'b1);
    tick('0, 1'b0, 1'b1, 1'b0);
    chk("R10 cleared", 32'h0, 1'b0);

    // R8/R9 all flags together, nonzero state
    doReset();
    cardState = 4'd5;
    tick(32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0);
    chk("R8/R9 all flags", (RDCLR | PREV) | (32'd5 << 9), 1'b1);
    tick(32'h0001_0000, 1'b0, 1'b1, 1'b0);
    chk("R9 folded out-of-range", PREV | 32'h0001_0000 | (32'd5 << 9), 1'b0);
    cardState = '0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule